// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters written by a host into non-return-to-zero frames on one output line. The line rests high. A frame is a low start bit, then 1 to 8 data bits sent least significant bit first, then an optional address-marker bit, then an optional parity bit, then one or two high stop bits. Each bit lasts a number of clocks set by a 16-bit divisor. The bit length is eight times the divisor plus one, except that a divisor of zero gives 16 clocks. The divisor and the frame options are sampled when a character enters the shifter. Any value may change while the shifter is idle.

The transmit path has two stages. The host writes into a holding buffer. When the shifter is free and the transmitter is enabled, the character moves into the shifter on the next clock. The buffer then frees up at once, so the host can queue the next character while the current one goes out. A character that is waiting in the buffer when the last stop bit ends starts with no idle gap. The block shows a buffer-ready flag and a shifter-empty flag. Its interrupt output is the buffer-ready flag gated by an interrupt enable. Clearing the transmit enable lets a frame that is in progress finish. After that the line stays high and any buffered character waits.

The shifter runs as a state machine with seven states. IDLE holds the line high. START drives the start bit. DATA sends the data bits. ADDR sends the address marker. PARITY sends the parity bit. STOP1 and STOP2 send the stop bits. The transitions are as follows:
- IDLE→START takes a buffered character when the transmitter is enabled.
- START→DATA happens at the end of the start bit.
- DATA leaves after its last data bit: →ADDR in address mode, otherwise →PARITY if parity is on, otherwise →STOP1.
- ADDR→PARITY happens if parity is on; otherwise ADDR→STOP1.
- PARITY→STOP1 follows the parity bit.
- STOP1→STOP2 happens when two stop bits are selected.
- At the end of the final stop bit the machine goes →START (back-to-back) if a character is waiting and the transmitter is enabled, otherwise →IDLE.

Top module: `serial_tx_dbuf`

## Requirements
- R1: Every bit of a frame lasts exactly P clocks. P = (divisor+1)*8 when the divisor is nonzero, and P = 16 when it is zero. The divisor is sampled when a character enters the shifter.
- R2: A frame is one start bit at 0, then char_len+1 data bits with bit 0 first (char_len 0 means 1 bit, 7 means 8 bits), then stop bits at 1. The line is 1 whenever no frame is in progress.
- R3: With parity_en=1, a parity bit follows the data bits (and the address bit, if present). It is computed over only the enabled data bits. With parity_odd=0 it makes the count of ones in data plus parity even; with parity_odd=1 it makes that count odd.
- R4: With two_stop=1 the frame ends with two stop-bit periods; with two_stop=0 it ends with one.
- R5: With addr_mode=1, one bit is inserted after the data and before parity. It equals the wr_addr_flag value that was written with the character.
- R6: An accepted write drives buf_ready low on the next clock. If the shifter is idle and the transmitter is enabled, the clock after that moves the character to the shifter: buf_ready returns high and the start bit begins. A character written during a frame starts immediately after that frame's last stop bit.
- R7: A write while buf_ready is low is ignored and does not change the queued character.
- R8: shift_empty is high exactly when no frame is in progress. It rises on the first clock after the last stop bit ends.
- R9: With tx_en low no new frame starts, the buffered character is kept, and the line stays high. Clearing tx_en during a frame lets that frame complete unchanged.
- R10: irq is high exactly when irq_en is high and buf_ready is high.
- R11: After reset txd is 1, buf_ready is 1 and shift_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable for buffer-ready |
| divisor | input | 16 | Bit-length divisor |
| char_len | input | 3 | Number of data bits minus one |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| addr_mode | input | 1 | Insert the address-marker bit |
| wr_valid | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| wr_addr_flag | input | 1 | Address-marker value for this character |
| txd | output | 1 | Serial output line |
| buf_ready | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | No frame in progress |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench targets several corner cases, listed here with the fault each one would expose:
- Divisors 0 and 1 both give a 16-clock bit. A design that handled zero as an ordinary divisor would send 8-clock bits.
- Parity is checked with data bits masked off by a short character length. A parity tree that took in the unused upper bits would flip the parity bit.
- A second character is queued during a frame, and a third write arrives while the buffer is full. Losing the queued character, or letting the third write overwrite it, would send the wrong second frame. Inserting an idle gap would move its start bit.
- The enable is dropped both before a frame and in the middle of one. A design that aborted the frame, or that started from a full buffer while disabled, would corrupt the line.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } stx_state_e;

endpackage

// File: rtl/stx_bit_timer.sv
`timescale 1ns/1ps
module stx_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    input  logic             run,
    output logic             tick
);
    localparam int PER_W = DIV_W + 4;

    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_d;
    logic [PER_W-1:0] cnt_q;

    // Bit length derived from the divisor; zero selects the fixed 16-clock bit
    always_comb begin
        if (divisor == '0)
            per_d = PER_W'(16);
        else
            per_d = (PER_W'(divisor) + PER_W'(1)) << 3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= PER_W'(16);
            cnt_q <= '0;
        end else if (restart) begin
            per_q <= per_d;
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == per_q - PER_W'(1))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + PER_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign tick = run && (cnt_q == per_q - PER_W'(1));

    // R1: the counter never runs past the latched bit length
    assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < per_q))
        else $error("bit counter beyond period");

    // R1: between bit boundaries the counter advances by exactly one
    assert_count_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !restart) |=> (cnt_q == $past(cnt_q) + PER_W'(1)))
        else $error("bit counter skipped");

endmodule

// File: rtl/stx_hold_buf.sv
`timescale 1ns/1ps
module stx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_addr,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              addr
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
            addr_q <= 1'b0;
        end else begin
            if (take)
                full_q <= 1'b0;
            else if (wr_valid && !full_q)
                full_q <= 1'b1;
            if (wr_valid && !full_q) begin
                data_q <= wr_data;
                addr_q <= wr_addr;
            end
        end
    end

    assign full = full_q;
    assign data = data_q;
    assign addr = addr_q;

    // R7: a write into an occupied buffer leaves the queued character alone
    assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full_q) |=> ($stable(data_q) && $stable(addr_q)))
        else $error("queued character overwritten");

    // R6: the shifter only takes a character that is actually queued
    assert_take_from_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q)
        else $error("take from empty buffer");

endmodule

// File: rtl/stx_frame_fsm.sv
`timescale 1ns/1ps
module stx_frame_fsm
    import stx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              addr_mode,
    output logic              take,
    output logic              txd,
    output logic              idle,
    output logic              run
);
    stx_state_e state_q, state_d;

    logic [DATA_W-1:0] sh_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic              pen_q;
    logic              two_q;
    logic              amode_q;
    logic              par_q;
    logic              adr_q;

    logic [DATA_W-1:0] mask;
    logic              par_d;
    logic              can_load;

    assign can_load = tx_en && buf_full;

    // Mask of the data bits that take part in this character
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            mask[i] = (i <= int'(len));
        par_d = (^(buf_data & mask)) ^ par_odd;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and load strobe
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (can_load) begin
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START: begin
                if (tick)
                    state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tick && (cnt_q == len_q)) begin
                    if (amode_q)
                        state_d = ST_ADDR;
                    else if (pen_q)
                        state_d = ST_PARITY;
                    else
                        state_d = ST_STOP1;
                end
            end
            ST_ADDR: begin
                if (tick)
                    state_d = pen_q ? ST_PARITY : ST_STOP1;
            end
            ST_PARITY: begin
                if (tick)
                    state_d = ST_STOP1;
            end
            ST_STOP1: begin
                if (tick) begin
                    if (two_q) begin
                        state_d = ST_STOP2;
                    end else if (can_load) begin
                        state_d = ST_START;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_STOP2: begin
                if (tick) begin
                    if (can_load) begin
                        state_d = ST_START;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Shift register and per-frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            pen_q   <= 1'b0;
            two_q   <= 1'b0;
            amode_q <= 1'b0;
            par_q   <= 1'b0;
            adr_q   <= 1'b0;
        end else if (take) begin
            sh_q    <= buf_data;
            cnt_q   <= '0;
            len_q   <= len;
            pen_q   <= par_en;
            two_q   <= two_stop;
            amode_q <= addr_mode;
            par_q   <= par_d;
            adr_q   <= buf_addr;
        end else if ((state_q == ST_DATA) && tick) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        idle = (state_q == ST_IDLE);
        run  = !idle;
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_ADDR:   txd = adr_q;
            ST_PARITY: txd = par_q;
            ST_STOP1:  txd = 1'b1;
            ST_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    // R2: idle line rests high
    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> txd)
        else $error("line low while idle");

    // R2: start bit is low
    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !txd)
        else $error("start bit not low");

    // R1: line level holds between bit boundaries
    assert_bit_level_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(txd))
        else $error("line changed inside a bit");

    // R9: disabled transmitter never leaves idle
    assert_disabled_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !tx_en) |=> idle)
        else $error("frame started while disabled");

    // R6: a load only happens with an enabled transmitter and a queued character
    assert_load_needs_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (tx_en && buf_full))
        else $error("load without character");

endmodule

// File: rtl/serial_tx_dbuf.sv
`timescale 1ns/1ps
module serial_tx_dbuf #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tx_en,
    input  logic                         irq_en,
    input  logic [DIV_W-1:0]             divisor,
    input  logic [$clog2(DATA_W)-1:0]    char_len,
    input  logic                         parity_en,
    input  logic                         parity_odd,
    input  logic                         two_stop,
    input  logic                         addr_mode,
    input  logic                         wr_valid,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         wr_addr_flag,
    output logic                         txd,
    output logic                         buf_ready,
    output logic                         shift_empty,
    output logic                         irq
);
    localparam int LEN_W = $clog2(DATA_W);

    logic              take;
    logic              tick;
    logic              run;
    logic              idle;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              buf_addr;

    stx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_addr  (wr_addr_flag),
        .take     (take),
        .full     (buf_full),
        .data     (buf_data),
        .addr     (buf_addr)
    );

    stx_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (take),
        .run     (run),
        .tick    (tick)
    );

    stx_frame_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_en     (tx_en),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .buf_addr  (buf_addr),
        .len       (char_len),
        .par_en    (parity_en),
        .par_odd   (parity_odd),
        .two_stop  (two_stop),
        .addr_mode (addr_mode),
        .take      (take),
        .txd       (txd),
        .idle      (idle),
        .run       (run)
    );

    assign buf_ready   = !buf_full;
    assign shift_empty = idle;
    assign irq         = irq_en && !buf_full;

    // R10: an accepted write clears the interrupt on the next clock
    assert_irq_drops_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_ready) |=> !irq)
        else $error("interrupt stayed high after write");

    // R6: accepted write makes the buffer busy on the next clock
    assert_ready_drops_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_ready) |=> !buf_ready)
        else $error("buffer still ready after write");

endmodule

// File: tb/sim_serial_tx_dbuf.sv
`timescale 1ns/1ps
module sim_serial_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       irq_en = 1'b1;
    logic [15:0] divisor = '0;
    logic [2:0] char_len = 3'd7;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       addr_mode = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_addr_flag = 1'b0;
    logic       txd, buf_ready, shift_empty, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    serial_tx_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .divisor(divisor), .char_len(char_len), .parity_en(parity_en),
        .parity_odd(parity_odd), .two_stop(two_stop), .addr_mode(addr_mode),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr_flag(wr_addr_flag),
        .txd(txd), .buf_ready(buf_ready), .shift_empty(shift_empty), .irq(irq)
    );

    // Fields: [31:16] divisor, [15:13] len, [12] parity_en, [11] parity_odd,
    // [10] two_stop, [9] addr_mode, [8] addr flag, [7:0] data
    localparam int NV = 8;
    localparam logic [31:0] VEC [0:NV-1] = '{
        32'h0000_E0A5,
        32'h0001_F03C,
        32'h0002_F801,
        32'h0000_90FF,
        32'h0000_1C02,
        32'h0001_D355,
        32'h0000_E680,
        32'h0003_5B06
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic int per_of(input logic [15:0] d);
        return (d == 16'd0) ? 16 : (int'(d) + 1) * 8;
    endfunction

    function automatic void frame_of(input logic [31:0] v, output logic [15:0] f, output int n);
        logic par;
        par = 1'b0;
        f = '1;
        n = 0;
        f[n] = 1'b0; n++;
        for (int i = 0; i <= int'(v[15:13]); i++) begin
            f[n] = v[i];
            par = par ^ v[i];
            n++;
        end
        if (v[9]) begin f[n] = v[8]; n++; end
        if (v[12]) begin f[n] = par ^ v[11]; n++; end
        f[n] = 1'b1; n++;
        if (v[10]) begin f[n] = 1'b1; n++; end
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [31:0] v);
        divisor    = v[31:16];
        char_len   = v[15:13];
        parity_en  = v[12];
        parity_odd = v[11];
        two_stop   = v[10];
        addr_mode  = v[9];
    endtask

    task automatic write_char(input logic [7:0] d, input logic a);
        wr_valid = 1'b1;
        wr_data = d;
        wr_addr_flag = a;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Called at the negedge just after the start bit began
    task automatic capture(input int p, input int n, output logic [15:0] got);
        got = '1;
        repeat (p / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (p) @(negedge clk);
            got[k] = txd;
        end
    endtask

    initial begin
        logic [15:0] exp_f, got_f;
        int n, p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 txd after reset", 32'(txd), 32'd1);
        chk("R11 buf_ready after reset", 32'(buf_ready), 32'd1);
        chk("R11 shift_empty after reset", 32'(shift_empty), 32'd1);
        chk("R10 irq with enable and empty buffer", 32'(irq), 32'd1);

        // Table of frame formats
        for (int vi = 0; vi < NV; vi++) begin
            apply_cfg(VEC[vi]);
            frame_of(VEC[vi], exp_f, n);
            p = per_of(VEC[vi][31:16]);
            write_char(VEC[vi][7:0], VEC[vi][8]);
            chk("R6 buf_ready low after write", 32'(buf_ready), 32'd0);
            chk("R10 irq low while buffer full", 32'(irq), 32'd0);
            chk("R6 line still idle one clock after write", 32'(txd), 32'd1);
            @(negedge clk);
            chk("R6 start bit begins", 32'(txd), 32'd0);
            chk("R6 buf_ready back after move", 32'(buf_ready), 32'd1);
            capture(p, n, got_f);
            chk("R2 R3 R4 R5 frame bits", 32'(got_f), 32'(exp_f));
            repeat (p - p / 2 - 1) @(negedge clk);
            chk("R8 shift_empty low in last stop clock", 32'(shift_empty), 32'd0);
            @(negedge clk);
            chk("R8 shift_empty high after frame", 32'(shift_empty), 32'd1);
            chk("R2 line high after frame", 32'(txd), 32'd1);
        end

        // R1: exact bit length, divisor 3 gives 32 clocks
        apply_cfg(32'h0003_E001);
        write_char(8'h01, 1'b0);
        @(negedge clk);
        repeat (31) @(negedge clk);
        chk("R1 start bit still low at clock 31", 32'(txd), 32'd0);
        @(negedge clk);
        chk("R1 first data bit at clock 32", 32'(txd), 32'd1);
        repeat (9 * 32) @(negedge clk);
        chk("R1 R8 idle after ten bits of 32 clocks", 32'(shift_empty), 32'd1);

        // R1: divisor 1 and divisor 0 both give 16 clocks
        apply_cfg(32'h0001_E001);
        write_char(8'h01, 1'b0);
        @(negedge clk);
        repeat (15) @(negedge clk);
        chk("R1 divisor 1 start low at clock 15", 32'(txd), 32'd0);
        @(negedge clk);
        chk("R1 divisor 1 data at clock 16", 32'(txd), 32'd1);
        repeat (9 * 16) @(negedge clk);

        // R6 / R7: back-to-back frames and a write into a full buffer
        apply_cfg(32'h0000_E000);
        write_char(8'h96, 1'b0);
        @(negedge clk);
        write_char(8'h3C, 1'b0);
        chk("R6 second character queued", 32'(buf_ready), 32'd0);
        write_char(8'hFF, 1'b0);
        chk("R7 buffer still full after extra write", 32'(buf_ready), 32'd0);
        repeat (160 - 1 - 2) @(negedge clk);
        chk("R6 first frame stop bit", 32'(txd), 32'd1);
        @(negedge clk);
        chk("R6 second start with no gap", 32'(txd), 32'd0);
        chk("R6 buffer freed by back-to-back move", 32'(buf_ready), 32'd1);
        frame_of(32'h0000_E03C, exp_f, n);
        capture(16, n, got_f);
        chk("R7 queued character not overwritten", 32'(got_f), 32'(exp_f));
        repeat (8) @(negedge clk);
        chk("R8 idle after second frame", 32'(shift_empty), 32'd1);

        // R9: disabled transmitter holds the character, then mid-frame disable
        tx_en = 1'b0;
        write_char(8'h5A, 1'b0);
        repeat (40) @(negedge clk);
        chk("R9 line high while disabled", 32'(txd), 32'd1);
        chk("R9 no frame while disabled", 32'(shift_empty), 32'd1);
        chk("R9 character kept in buffer", 32'(buf_ready), 32'd0);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R9 start after enable", 32'(txd), 32'd0);
        tx_en = 1'b0;
        frame_of(32'h0000_E05A, exp_f, n);
        capture(16, n, got_f);
        chk("R9 frame completes after disable", 32'(got_f), 32'(exp_f));
        repeat (28) @(negedge clk);
        chk("R9 line high after disabled finish", 32'(txd), 32'd1);
        chk("R9 shifter empty after disabled finish", 32'(shift_empty), 32'd1);
        tx_en = 1'b1;

        // R10: interrupt enable gating
        irq_en = 1'b0;
        @(negedge clk);
        chk("R10 irq low with enable off", 32'(irq), 32'd0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq high with enable on and buffer ready", 32'(irq), 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule